// File: doc/BRIEF.md
# Clock Divider Change Sequencer

This block moves a core clock from its present divide ratio to a newly requested one. Five ratios are available: 1, 2, 4, 6 and 8. A change touches three pieces of state in a fixed order: the divider-mode code, the memory-controller refresh-count value and the DRAM self-refresh enable. The block chooses that order from the direction of the change. It routes some changes through divide-by-2. It also holds back each following step until the clock has relocked or the refresh counters have drained.

A requester presents a ratio index and pulses a start strobe while the block is not busy. The block raises busy for the whole change and pulses done for one cycle when the change is complete. A request for the ratio already in use completes at once and drives no output. An index with no ratio behind it raises a one-cycle error pulse and is otherwise dropped. A refresh count is computed for each ratio at elaboration from the base clock frequency, so the block needs no run-time divider.

Top module: `clkdiv_seq`

## Requirements
- R1: Ratio index 0, 1, 2, 3 and 4 select divide-by 1, 2, 4, 6 and 8. Their divider-mode codes on `div_code_o` are 0, 1, 3, 2 and 4. After reset the code is 0, self-refresh is off, and busy, done and err are low.
- R2: The refresh count for divisor D is floor(BASE_MHZ × 7800 / (64000 × D)). With the default 500 MHz base this gives 60, 30, 15, 10 and 7. After reset the count is the divide-by-1 value.
- R3: A change from divide-by-1 to divide-by-4, -6 or -8 goes through two divider writes with code 1 first. So does a change from any of those three ratios back to divide-by-1.
- R4: A change from divide-by-2 to divide-by-1 clears self-refresh first, then writes the divider code, then writes the new refresh count.
- R5: A change from divide-by-1 to divide-by-2 writes the refresh count first, then the divider code, and sets self-refresh last.
- R6: Between two ratios that are both 2 or above, slowing down writes the refresh count before the divider code. Speeding up writes the divider code first and the refresh count after it.
- R7: After every divider write, at least RELOCK_CYC clock cycles pass before the next output change or done.
- R8: A refresh-count write that comes before a slowing divider write, made while self-refresh is off, is followed by a gap of at least 64 × (old count + new count) × old divisor + DRAIN_MARGIN cycles before the next step.
- R9: A start whose index equals the current ratio changes no output, keeps busy low, and pulses done in the cycle after the start.
- R10: A start pulsed while busy is high has no effect on the change in progress or on the final ratio.
- R11: A start with an index above 4 pulses err for one cycle, leaves busy and done low, and changes no other output.
- R12: busy is high from the cycle after an accepted start until done. done is a single-cycle pulse, and busy is low while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all waits are counted on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, sampled while not busy |
| ratio_idx_i | input | 3 | Requested ratio index (0..4) |
| div_code_o | output | 3 | Divider-mode code |
| refr_cnt_o | output | REFR_W (7) | Refresh-count value for the memory controller |
| sref_en_o | output | 1 | DRAM self-refresh enable |
| busy_o | output | 1 | Change in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse for an out-of-range index |

## Verification
The directed cases cover five kinds of change. Single-step slowing and speeding changes between ratios of 2 or above tell the two update orders apart. The 1→2 and 2→1 changes show where the self-refresh toggle falls. Two-hop changes to and from divide-by-1 show that divide-by-2 is always used as the intermediate ratio. The 1→2 step with self-refresh off is the only place the long drain gap appears, which separates it from the short relock gap.

Same-ratio requests, out-of-range indexes and a start injected in the middle of a drain show that these inputs leave the outputs alone. Each case compares the full logged sequence of output changes, with their values and the cycle gaps between them, against a sequence the bench builds from the rules.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int NUM_RATIOS = 5;
    localparam int IDX_W      = 3;
    localparam int CODE_W     = 3;
    localparam int SLOTS      = 3;

    localparam logic [IDX_W-1:0] IDX_DIV1  = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_DIV2  = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(NUM_RATIOS);

    typedef enum logic [2:0] {
        OP_NONE, OP_SREF_CLR, OP_SREF_SET, OP_DIV, OP_REF, OP_REF_SLOW
    } op_e;

    typedef enum logic [1:0] {ST_IDLE, ST_PLAN, ST_EXEC, ST_WAIT} state_e;

    typedef enum logic [1:0] {GO_EXEC, GO_PLAN, GO_FIN} go_e;

    function automatic logic [CODE_W-1:0] idx_to_code(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0:    return 3'd0;
            3'd1:    return 3'd1;
            3'd2:    return 3'd3;
            3'd3:    return 3'd2;
            3'd4:    return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic int unsigned idx_to_div(input int unsigned idx);
        case (idx)
            0:       return 1;
            1:       return 2;
            2:       return 4;
            3:       return 6;
            4:       return 8;
            default: return 1;
        endcase
    endfunction

    // floor(base_Hz * 7.8us / (64 * divisor)), written with the base in MHz
    function automatic int unsigned refr_count(input int unsigned base_mhz,
                                               input int unsigned idx);
        longint unsigned num;
        longint unsigned den;
        num = longint'(base_mhz) * 64'd7800;
        den = 64'd64000 * longint'(idx_to_div(idx));
        return 32'(num / den);
    endfunction
endpackage

// File: rtl/clkdiv_refr_table.sv
module clkdiv_refr_table
    import clkdiv_pkg::*;
#(
    parameter int unsigned BASE_MHZ = 500,
    parameter int          REFR_W   = 7
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [REFR_W-1:0] cnt_o
);
    localparam int ENTRIES = 2 ** IDX_W;

    logic [REFR_W-1:0] tbl [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        if (g < NUM_RATIOS) begin : g_ratio
            localparam int unsigned VAL = refr_count(BASE_MHZ, g);
            assign tbl[g] = REFR_W'(VAL);
        end else begin : g_unused
            assign tbl[g] = '0;
        end
    end

    assign cnt_o = tbl[idx_i];
endmodule

// File: rtl/clkdiv_hop_plan.sv
module clkdiv_hop_plan
    import clkdiv_pkg::*;
(
    input  logic [IDX_W-1:0]    from_i,
    input  logic [IDX_W-1:0]    to_i,
    output op_e [SLOTS-1:0]     ops_o
);
    // slot 0 executes first; index order matches divisor order
    always_comb begin
        if (from_i == IDX_DIV2 && to_i == IDX_DIV1) begin
            ops_o[0] = OP_SREF_CLR;
            ops_o[1] = OP_DIV;
            ops_o[2] = OP_REF;
        end else if (from_i == IDX_DIV1 && to_i == IDX_DIV2) begin
            ops_o[0] = OP_REF_SLOW;
            ops_o[1] = OP_DIV;
            ops_o[2] = OP_SREF_SET;
        end else if (from_i < to_i) begin
            ops_o[0] = OP_REF_SLOW;
            ops_o[1] = OP_DIV;
            ops_o[2] = OP_NONE;
        end else begin
            ops_o[0] = OP_DIV;
            ops_o[1] = OP_REF;
            ops_o[2] = OP_NONE;
        end
    end
endmodule

// File: rtl/clkdiv_wait_timer.sv
module clkdiv_wait_timer #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             idle_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign idle_o = (cnt_q == '0);

    // R7 / R8: an expired wait stays expired until reloaded
    a_r7_timer_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
    import clkdiv_pkg::*;
#(
    parameter int unsigned BASE_MHZ     = 500,
    parameter int          REFR_W       = 7,
    parameter int unsigned RELOCK_CYC   = 16,
    parameter int unsigned DRAIN_MARGIN = 4,
    parameter int          CNT_W        = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  ratio_idx_i,
    output logic [CODE_W-1:0] div_code_o,
    output logic [REFR_W-1:0] refr_cnt_o,
    output logic              sref_en_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    localparam logic [REFR_W-1:0] REFR_RST = REFR_W'(refr_count(BASE_MHZ, 0));

    typedef struct packed {
        state_e             st;
        go_e                pend;
        logic [IDX_W-1:0]   tgt;
        logic [IDX_W-1:0]   hop_to;
        logic [IDX_W-1:0]   cur;
        logic               two_hop;
        logic               hop;
        op_e [SLOTS-1:0]    ops;
        logic [1:0]         slot;
        logic [CODE_W-1:0]  code;
        logic [REFR_W-1:0]  refr;
        logic               sref;
        logic               busy;
        logic               done;
        logic               err;
    } seq_t;

    seq_t d, q;

    op_e [SLOTS-1:0]   plan_ops;
    logic [REFR_W-1:0] rom_cnt;
    logic              tmr_load, tmr_idle;
    logic [CNT_W-1:0]  tmr_val;
    op_e               cur_op, nxt_op;
    go_e               go, go_sel;
    logic              fire, need_wait, two_new;
    logic [31:0]       drain_cyc;

    clkdiv_refr_table #(.BASE_MHZ(BASE_MHZ), .REFR_W(REFR_W)) u_table (
        .idx_i (q.hop_to),
        .cnt_o (rom_cnt)
    );

    clkdiv_hop_plan u_plan (
        .from_i (q.cur),
        .to_i   (q.hop_to),
        .ops_o  (plan_ops)
    );

    clkdiv_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .idle_o (tmr_idle)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.err     = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        fire      = 1'b0;
        need_wait = 1'b0;
        go_sel    = q.pend;

        cur_op = q.ops[q.slot];
        nxt_op = (q.slot < 2'(SLOTS - 1)) ? q.ops[q.slot + 2'd1] : OP_NONE;
        if (nxt_op != OP_NONE)        go = GO_EXEC;
        else if (q.two_hop && !q.hop) go = GO_PLAN;
        else                          go = GO_FIN;

        // wait after a slowing refresh write: drain old and new counts at the old clock
        drain_cyc = (32'(q.refr) + 32'(rom_cnt)) * 32'd64 * idx_to_div(32'(q.cur))
                  + 32'(DRAIN_MARGIN);

        two_new = (q.cur == IDX_DIV1 && ratio_idx_i > IDX_DIV2) ||
                  (q.cur > IDX_DIV2 && ratio_idx_i == IDX_DIV1);

        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (ratio_idx_i >= IDX_LIMIT) begin
                        d.err = 1'b1;
                    end else if (ratio_idx_i == q.cur) begin
                        d.done = 1'b1;
                    end else begin
                        d.busy    = 1'b1;
                        d.tgt     = ratio_idx_i;
                        d.two_hop = two_new;
                        d.hop     = 1'b0;
                        d.hop_to  = two_new ? IDX_DIV2 : ratio_idx_i;
                        d.st      = ST_PLAN;
                    end
                end
            end
            ST_PLAN: begin
                d.ops  = plan_ops;
                d.slot = 2'd0;
                d.st   = ST_EXEC;
            end
            ST_EXEC: begin
                case (cur_op)
                    OP_SREF_CLR: d.sref = 1'b0;
                    OP_SREF_SET: d.sref = 1'b1;
                    OP_DIV: begin
                        d.code    = idx_to_code(q.hop_to);
                        d.cur     = q.hop_to;
                        need_wait = 1'b1;
                        tmr_val   = CNT_W'(RELOCK_CYC);
                    end
                    OP_REF: d.refr = rom_cnt;
                    OP_REF_SLOW: begin
                        d.refr = rom_cnt;
                        if (!q.sref) begin
                            need_wait = 1'b1;
                            tmr_val   = CNT_W'(drain_cyc);
                        end
                    end
                    default: ;
                endcase
                if (go == GO_EXEC) d.slot = q.slot + 2'd1;
                if (go == GO_PLAN) begin
                    d.hop    = 1'b1;
                    d.hop_to = q.tgt;
                end
                if (need_wait) begin
                    tmr_load = 1'b1;
                    d.pend   = go;
                    d.st     = ST_WAIT;
                end else begin
                    fire   = 1'b1;
                    go_sel = go;
                end
            end
            ST_WAIT: begin
                if (tmr_idle) fire = 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase

        if (fire) begin
            case (go_sel)
                GO_EXEC: d.st = ST_EXEC;
                GO_PLAN: d.st = ST_PLAN;
                default: begin
                    d.st   = ST_IDLE;
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.refr <= REFR_RST;
        end else begin
            q <= d;
        end
    end

    assign div_code_o = q.code;
    assign refr_cnt_o = q.refr;
    assign sref_en_o  = q.sref;
    assign busy_o     = q.busy;
    assign done_o     = q.done;
    assign err_o      = q.err;

    // R1: only the five defined codes ever appear
    a_r1_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        div_code_o <= 3'd4);

    // R3: no direct jump between divide-by-1 and anything but divide-by-2
    a_r3_leave_div1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(div_code_o) && $past(div_code_o) == 3'd0) |-> div_code_o == 3'd1);
    a_r3_enter_div1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(div_code_o) && div_code_o == 3'd0) |-> $past(div_code_o) == 3'd1);

    // R4 / R5: self-refresh toggles only while the divider sits at divide-by-2
    a_r5_sref_at_div2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sref_en_o) |-> div_code_o == 3'd1);

    // R12: divider moves only inside a busy window; done is a lone pulse outside it
    a_r12_div_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_code_o) |-> busy_o);
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R11: an error pulse never coincides with activity
    a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!busy_o && !done_o));
endmodule

// File: tb/clkdiv_seq_tb.sv
`timescale 1ns/1ps
module clkdiv_seq_tb;
    localparam int unsigned BASE_MHZ = 500;
    localparam int RELOCK = 16;
    localparam int MARGIN = 4;
    localparam int K_DIV = 1, K_REF = 2, K_SREF = 3, K_DONE = 4;
    localparam int BIG = 1000000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] idx = '0;
    logic [2:0] code;
    logic [6:0] refr;
    logic sref, busy, done, err;

    clkdiv_seq #(
        .BASE_MHZ(BASE_MHZ), .RELOCK_CYC(RELOCK), .DRAIN_MARGIN(MARGIN)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ratio_idx_i(idx),
        .div_code_o(code), .refr_cnt_o(refr), .sref_en_o(sref),
        .busy_o(busy), .done_o(done), .err_o(err)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    int ev_kind[64], ev_val[64], ev_cyc[64];
    int ev_n = 0;
    int x_kind[16], x_val[16], x_min[16], x_max[16];
    string x_req[16];
    int x_n = 0;
    int m_idx = 0;
    bit m_sref = 1'b0;
    logic [2:0] p_code = '0;
    logic [6:0] p_refr = '0;
    logic p_sref = 1'b0, p_done = 1'b0;

    function automatic int b_div(int i);
        case (i) 0: return 1; 1: return 2; 2: return 4; 3: return 6; default: return 8; endcase
    endfunction
    function automatic int b_code(int i);
        case (i) 0: return 0; 1: return 1; 2: return 3; 3: return 2; default: return 4; endcase
    endfunction
    function automatic int b_cnt(int i);
        return (int'(BASE_MHZ) * 7800) / (64000 * b_div(i));
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic log_ev(int k, int v);
        if (ev_n < 64) begin
            ev_kind[ev_n] = k; ev_val[ev_n] = v; ev_cyc[ev_n] = cyc;
        end
        ev_n++;
    endtask

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (code !== p_code) log_ev(K_DIV, int'(code));
            if (refr !== p_refr) log_ev(K_REF, int'(refr));
            if (sref !== p_sref) log_ev(K_SREF, int'(sref));
            if (done === 1'b1 && p_done !== 1'b1) log_ev(K_DONE, 1);
        end
        p_code = code; p_refr = refr; p_sref = sref; p_done = done;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic push(int k, int v, int mn, int mx, string r);
        x_kind[x_n] = k; x_val[x_n] = v; x_min[x_n] = mn; x_max[x_n] = mx; x_req[x_n] = r;
        x_n++;
    endtask

    task automatic ref_step(int a, int b, string r);
        int n;
        if (!m_sref) begin
            n = 64 * (b_cnt(a) + b_cnt(b)) * b_div(a) + MARGIN;
            push(K_REF, b_cnt(b), n, n + 4, r);
        end else begin
            push(K_REF, b_cnt(b), 0, BIG, r);
        end
    endtask

    task automatic add_hop(int a, int b);
        if (a == 1 && b == 0) begin
            push(K_SREF, 0, 0, BIG, "R4");
            push(K_DIV, b_code(0), RELOCK, RELOCK + 4, "R4");
            push(K_REF, b_cnt(0), 0, BIG, "R4");
            m_sref = 1'b0;
        end else if (a == 0 && b == 1) begin
            ref_step(0, 1, "R5");
            push(K_DIV, b_code(1), RELOCK, RELOCK + 4, "R5");
            push(K_SREF, 1, 0, BIG, "R5");
            m_sref = 1'b1;
        end else if (a < b) begin
            ref_step(a, b, "R6");
            push(K_DIV, b_code(b), RELOCK, RELOCK + 4, "R6");
        end else begin
            push(K_DIV, b_code(b), RELOCK, RELOCK + 4, "R6");
            push(K_REF, b_cnt(b), 0, BIG, "R6");
        end
    endtask

    task automatic run_change(int t, bit inject);
        bit same;
        bit two;
        int n;
        int ndiv;
        int g;
        string tag;
        same = (t == m_idx);
        two  = (m_idx == 0 && t >= 2) || (m_idx >= 2 && t == 0);
        ev_n = 0;
        x_n  = 0;
        if (!same) begin
            if (two) begin
                add_hop(m_idx, 1);
                add_hop(1, t);
            end else begin
                add_hop(m_idx, t);
            end
        end
        push(K_DONE, 1, 0, BIG, "R12");
        tag = same ? "R9" : (inject ? "R10" : "R12");

        @(negedge clk); start = 1'b1; idx = 3'(t);
        @(negedge clk); start = 1'b0;
        if (same) begin
            chk(done == 1'b1, "R9", "done right after same-ratio start", int'(done), 1);
            chk(busy == 1'b0, "R9", "busy stays low on same ratio", int'(busy), 0);
        end else begin
            chk(busy == 1'b1, "R12", "busy after accepted start", int'(busy), 1);
        end
        if (inject) begin
            repeat (40) @(negedge clk);
            start = 1'b1; idx = 3'd4;
            @(negedge clk); start = 1'b0;
            chk(busy == 1'b1, "R10", "busy kept through ignored start", int'(busy), 1);
        end
        n = 0;
        while (done !== 1'b1 && n < 30000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R12", "done reached", int'(done), 1);
        @(negedge clk);
        chk(done == 1'b0, "R12", "done is one cycle", int'(done), 0);
        chk(busy == 1'b0, "R12", "busy low after done", int'(busy), 0);
        repeat (10) @(negedge clk);

        chk(ev_n == x_n, tag, "number of output changes", ev_n, x_n);
        for (int k = 0; k < ev_n && k < x_n; k++) begin
            chk(ev_kind[k] == x_kind[k], x_req[k], "step kind in order", ev_kind[k], x_kind[k]);
            if (x_kind[k] == K_DIV)
                chk(ev_val[k] == x_val[k], "R1", "divider code", ev_val[k], x_val[k]);
            else if (x_kind[k] == K_REF)
                chk(ev_val[k] == x_val[k], "R2", "refresh count", ev_val[k], x_val[k]);
            else
                chk(ev_val[k] == x_val[k], x_req[k], "flag value", ev_val[k], x_val[k]);
            if (k + 1 < ev_n && x_min[k] > 0) begin
                g = ev_cyc[k + 1] - ev_cyc[k];
                if (x_kind[k] == K_DIV)
                    chk(g >= x_min[k] && g <= x_max[k], "R7", "relock gap", g, x_min[k]);
                else
                    chk(g >= x_min[k] && g <= x_max[k], "R8", "drain gap", g, x_min[k]);
            end
        end
        if (two) begin
            ndiv = 0;
            for (int k = 0; k < ev_n && k < 64; k++)
                if (ev_kind[k] == K_DIV) ndiv++;
            chk(ndiv == 2, "R3", "two divider writes", ndiv, 2);
            chk(ev_kind[0] != K_DIV || ev_val[0] == 1, "R3", "first hop lands on code 1", ev_val[0], 1);
        end
        chk(int'(code) == b_code(t), inject ? "R10" : "R1", "final divider code", int'(code), b_code(t));
        m_idx = t;
    endtask

    task automatic run_bad(int t);
        ev_n = 0;
        @(negedge clk); start = 1'b1; idx = 3'(t);
        @(negedge clk); start = 1'b0;
        chk(err == 1'b1, "R11", "err on bad index", int'(err), 1);
        chk(busy == 1'b0, "R11", "busy low on bad index", int'(busy), 0);
        chk(done == 1'b0, "R11", "no done on bad index", int'(done), 0);
        @(negedge clk);
        chk(err == 1'b0, "R11", "err is one cycle", int'(err), 0);
        repeat (10) @(negedge clk);
        chk(ev_n == 0, "R11", "no output change on bad index", ev_n, 0);
        chk(int'(code) == b_code(m_idx), "R11", "code unchanged", int'(code), b_code(m_idx));
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(code == 3'd0, "R1", "reset divider code", int'(code), 0);
        chk(int'(refr) == b_cnt(0), "R2", "reset refresh count", int'(refr), b_cnt(0));
        chk(sref == 1'b0, "R1", "reset self-refresh", int'(sref), 0);
        chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
        chk(done == 1'b0, "R1", "reset done", int'(done), 0);
        chk(err == 1'b0, "R1", "reset err", int'(err), 0);

        run_change(1, 1'b0);   // div1 -> div2 with drain
        run_change(0, 1'b0);   // div2 -> div1
        run_change(3, 1'b0);   // div1 -> div6 through div2
        run_change(4, 1'b0);   // div6 -> div8 slowing
        run_change(2, 1'b0);   // div8 -> div4 speeding
        run_change(0, 1'b0);   // div4 -> div1 through div2
        run_change(0, 1'b0);   // same ratio
        run_bad(5);
        run_bad(7);
        run_change(2, 1'b1);   // div1 -> div4, start injected during drain
        run_change(2, 1'b0);   // same ratio
        run_change(1, 1'b0);   // div4 -> div2 speeding
        run_change(4, 1'b0);   // div2 -> div8 slowing, self-refresh on
        run_change(0, 1'b0);   // div8 -> div1 through div2

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule